// File: doc/BRIEF.md
# Voting and Resume Recovery Controller

This controller sits beside the functional units of a wide-issue pipeline in which every operation runs twice: once on its own unit and once as a reference copy. When a result checker reports that a unit disagrees with its reference value for the first time, the controller holds the execute and fetch stages. It replays the disputed operation on a third unit and uses that third result to decide which of the two original units is broken.

The block has three modes. In normal mode each unit's scheduled control word passes straight through. Any operation whose operator is already recorded as broken on its unit is moved in the same cycle to an idle healthy unit. In voting mode the captured control word is steered onto a spare unit, and the comparison of the replayed result with the reference value is sampled once the replay has had its full latency. The outcome sets a bit in a per-unit, per-operator fault vector and picks which unit writes back. Resume mode then keeps the stall for the remaining pipeline latency before the held instructions restart. If several units report in the same cycle, each report is voted in turn.

Top module: `rr_vote_recovery`

## Requirements
- R1: During and after reset the mode is normal (code 0), both stall outputs are low and every fault-vector bit is clear.
- R2: In normal mode with no new report and no recorded fault for a slot's operator, `ctrlOut` for every unit equals that unit's `fuCtrl`, and `wbEn` equals `fuValid`.
- R3: A report on a valid slot whose operator is not recorded as broken on that unit is a new fault. It forces `wbEn` of that unit low in the same cycle, and the mode is voting (code 1) on the next cycle.
- R4: One new fault gives voting for MAX_LAT+1 cycles, then resume (code 2) for MAX_LAT cycles. Both stalls are high in exactly these 2·MAX_LAT+1 cycles and low in normal mode.
- R5: In the first voting cycle the spare unit gets the captured control word, and every other `ctrlOut` is zero. The spare is the lowest-numbered unit that is neither the flagged unit nor its reference and whose fault bit for the operator is clear. While voting or resuming, all other `ctrlOut` and `wbEn` are zero.
- R6: In the last voting cycle `voteEq` is sampled. If it is 1 and a spare exists, the flagged unit's bit for the operator is set and `wbEn` of the spare is pulsed.
- R7: If `voteEq` is 0 and a spare exists, the reference unit's bit for the operator is set and `wbEn` of the flagged unit is pulsed, committing its held result.
- R8: If no spare exists, no fault bit is set and `wbEn` of the flagged unit is pulsed in the last voting cycle.
- R9: In normal mode a valid slot whose operator is recorded as broken on its unit is moved in the same cycle. The lowest-numbered idle unit with that operator healthy (idle units are claimed by lower-numbered slots first) gets the control word and `wbEn`=1, and the source unit gets `ctrlOut`=0 and `wbEn`=0. If no unit qualifies, the slot runs unchanged on its own unit.
- R10: A report is ignored, and neither changes the mode nor clears a write-back, when the slot is not valid, when the slot's operator is already recorded as broken on that unit, or when the mode is not normal.
- R11: New reports raised in the same cycle are voted one at a time, lowest unit number first. After each resume phase the next pending report starts a new voting phase at once, without passing through normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fuValid | input | NUM_FU | Slot holds a scheduled operation |
| fuOpc | input | NUM_FU x OPC_W | Operator class of each slot |
| fuCtrl | input | NUM_FU x CW_W | Scheduled control word of each slot |
| fuRef | input | NUM_FU x IDX_W | Unit that ran the reference copy of each slot |
| errDet | input | NUM_FU | Checker mismatch report for each slot |
| voteEq | input | 1 | Replayed result equals reference value |
| mode | output | 2 | 0 normal, 1 voting, 2 resume |
| stallExec | output | 1 | Hold the execute stage |
| stallFetch | output | 1 | Hold the fetch stage |
| ctrlOut | output | NUM_FU x CW_W | Control word steered to each unit |
| wbEn | output | NUM_FU | Write-back enable of each unit |
| faultVec | output | NUM_FU x NUM_OPS | Recorded broken operators per unit |

## Verification
Two functions can fall in the same normal-mode cycle. One slot can be moved off a known-broken operator while another slot raises a new first-time report, and both compete for the same idle units and write-back enables. The stimulus provokes this by recording a few faults through directed votes and then running random slot occupancy, operators and sparse reports. A reference model in the bench computes the steering and write-back for every unit and compares them with the ports each cycle. A second overlap occurs when several reports arrive together: the pending ones have to be voted back to back while the fault vector changes between votes. This is judged by the model's pending set, by per-phase stall counts and by the spare chosen in each voting phase.

// File: rtl/rr_vote_pkg.sv
`timescale 1ns/1ps
package rr_vote_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_VOTE   = 2'd1,
    MODE_RESUME = 2'd2
  } modeE;

  // strobes from the mode controller to the steering datapath
  typedef struct packed {
    logic capture;  // latch new reports and their context
    logic issue;    // drive the captured word onto the spare unit
    logic decide;   // sample the vote and update fault vector
  } strobeS;

  localparam int DEF_NUM_FU  = 4;
  localparam int DEF_NUM_OPS = 4;
  localparam int DEF_CW_W    = 12;
  localparam int DEF_MAX_LAT = 2;

endpackage

// File: rtl/rr_mode_ctrl.sv
`timescale 1ns/1ps
module rr_mode_ctrl
  import rr_vote_pkg::*;
#(
  parameter int MAX_LAT = DEF_MAX_LAT
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   anyNew,
  input  logic   pendAny,
  output modeE   modeQ,
  output strobeS strobe,
  output logic   stall
);

  localparam int CNT_W = $clog2(MAX_LAT + 1) + 1;
  localparam logic [CNT_W-1:0] VOTE_LAST   = CNT_W'(MAX_LAT);
  localparam logic [CNT_W-1:0] RESUME_LAST = CNT_W'(MAX_LAT - 1);

  logic [CNT_W-1:0] cntQ;

  always_comb begin
    strobe.capture = (modeQ == MODE_NORMAL) && anyNew;
    strobe.issue   = (modeQ == MODE_VOTE) && (cntQ == '0);
    strobe.decide  = (modeQ == MODE_VOTE) && (cntQ == VOTE_LAST);
  end

  assign stall = (modeQ != MODE_NORMAL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_NORMAL;
      cntQ  <= '0;
    end else begin
      unique case (modeQ)
        MODE_NORMAL: begin
          cntQ <= '0;
          if (anyNew) modeQ <= MODE_VOTE;
        end
        MODE_VOTE: begin
          if (cntQ == VOTE_LAST) begin
            modeQ <= MODE_RESUME;
            cntQ  <= '0;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        MODE_RESUME: begin
          if (cntQ == RESUME_LAST) begin
            modeQ <= pendAny ? MODE_VOTE : MODE_NORMAL;
            cntQ  <= '0;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        default: begin
          modeQ <= MODE_NORMAL;
          cntQ  <= '0;
        end
      endcase
    end
  end

  assert_enter_vote_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_NORMAL && anyNew) |=> (modeQ == MODE_VOTE));

  assert_vote_to_resume_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_VOTE && cntQ == VOTE_LAST) |=> (modeQ == MODE_RESUME));

  assert_resume_exit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_RESUME && cntQ == RESUME_LAST) |=> (modeQ != MODE_RESUME));

endmodule

// File: rtl/rr_steer_dp.sv
`timescale 1ns/1ps
module rr_steer_dp
  import rr_vote_pkg::*;
#(
  parameter int NUM_FU  = DEF_NUM_FU,
  parameter int NUM_OPS = DEF_NUM_OPS,
  parameter int CW_W    = DEF_CW_W,
  parameter int OPC_W   = $clog2(NUM_OPS),
  parameter int IDX_W   = $clog2(NUM_FU)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  modeE                            modeQ,
  input  strobeS                          strobe,
  input  logic [NUM_FU-1:0]               fuValid,
  input  logic [NUM_FU-1:0][OPC_W-1:0]    fuOpc,
  input  logic [NUM_FU-1:0][CW_W-1:0]     fuCtrl,
  input  logic [NUM_FU-1:0][IDX_W-1:0]    fuRef,
  input  logic [NUM_FU-1:0]               errDet,
  input  logic                            voteEq,
  output logic                            anyNew,
  output logic                            pendAny,
  output logic [NUM_FU-1:0][CW_W-1:0]     ctrlOut,
  output logic [NUM_FU-1:0]               wbEn,
  output logic [NUM_FU-1:0][NUM_OPS-1:0]  faultVec
);

  logic [NUM_FU-1:0][NUM_OPS-1:0] faultQ;
  logic [NUM_FU-1:0]              pendQ;
  logic [NUM_FU-1:0][CW_W-1:0]    ctxCtrl;
  logic [NUM_FU-1:0][OPC_W-1:0]   ctxOpc;
  logic [NUM_FU-1:0][IDX_W-1:0]   ctxRef;

  logic [NUM_FU-1:0] newErr;
  logic [NUM_FU-1:0] knownBad;
  logic [IDX_W-1:0]  curFu;
  logic [OPC_W-1:0]  curOpc;
  logic [IDX_W-1:0]  curRef;
  logic [IDX_W-1:0]  spareFu;
  logic              spareOk;
  logic [NUM_FU-1:0] freeMask;
  logic              found;

  // first-time fault detection and known-fault lookup per slot
  for (genvar u = 0; u < NUM_FU; u++) begin : g_slot
    assign knownBad[u] = fuValid[u] && faultQ[u][fuOpc[u]];
    assign newErr[u]   = (modeQ == MODE_NORMAL) && fuValid[u] && errDet[u] && !faultQ[u][fuOpc[u]];
  end

  assign anyNew   = |newErr;
  assign pendAny  = |pendQ;
  assign faultVec = faultQ;

  // lowest pending unit is voted first
  always_comb begin
    curFu = '0;
    for (int i = NUM_FU - 1; i >= 0; i--) begin
      if (pendQ[i]) curFu = IDX_W'(i);
    end
  end

  assign curOpc = ctxOpc[curFu];
  assign curRef = ctxRef[curFu];

  // spare: lowest unit outside the disputed pair with a healthy operator
  always_comb begin
    spareFu = '0;
    spareOk = 1'b0;
    for (int i = NUM_FU - 1; i >= 0; i--) begin
      if ((IDX_W'(i) != curFu) && (IDX_W'(i) != curRef) && !faultQ[i][curOpc]) begin
        spareFu = IDX_W'(i);
        spareOk = 1'b1;
      end
    end
  end

  // control-word steering and write-back selection
  always_comb begin
    ctrlOut  = '0;
    wbEn     = '0;
    freeMask = ~fuValid;
    found    = 1'b0;
    if (modeQ == MODE_NORMAL) begin
      for (int u = 0; u < NUM_FU; u++) begin
        ctrlOut[u] = fuCtrl[u];
        wbEn[u]    = fuValid[u] && !newErr[u];
      end
      for (int u = 0; u < NUM_FU; u++) begin
        if (knownBad[u]) begin
          found = 1'b0;
          for (int w = 0; w < NUM_FU; w++) begin
            if (!found && freeMask[w] && !faultQ[w][fuOpc[u]]) begin
              found       = 1'b1;
              freeMask[w] = 1'b0;
              ctrlOut[w]  = fuCtrl[u];
              wbEn[w]     = 1'b1;
            end
          end
          if (found) begin
            ctrlOut[u] = '0;
            wbEn[u]    = 1'b0;
          end
        end
      end
    end else begin
      if (strobe.issue && spareOk) ctrlOut[spareFu] = ctxCtrl[curFu];
      if (strobe.decide) begin
        if (spareOk && voteEq) wbEn[spareFu] = 1'b1;
        else                   wbEn[curFu]   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultQ  <= '0;
      pendQ   <= '0;
      ctxCtrl <= '0;
      ctxOpc  <= '0;
      ctxRef  <= '0;
    end else begin
      if (strobe.capture) begin
        pendQ <= newErr;
        for (int u = 0; u < NUM_FU; u++) begin
          if (newErr[u]) begin
            ctxCtrl[u] <= fuCtrl[u];
            ctxOpc[u]  <= fuOpc[u];
            ctxRef[u]  <= fuRef[u];
          end
        end
      end
      if (strobe.decide) begin
        pendQ[curFu] <= 1'b0;
        if (spareOk) begin
          if (voteEq) faultQ[curFu][curOpc]  <= 1'b1;
          else        faultQ[curRef][curOpc] <= 1'b1;
        end
      end
    end
  end

  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (faultQ & $past(faultQ)) == $past(faultQ));

  assert_single_wb_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != MODE_NORMAL) |-> $onehot0(wbEn));

  assert_pend_drop_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decide |=> ($countones(pendQ) == $countones($past(pendQ)) - 1));

  assert_quiet_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != MODE_NORMAL && !strobe.issue) |-> (ctrlOut == '0));

endmodule

// File: rtl/rr_vote_recovery.sv
`timescale 1ns/1ps
module rr_vote_recovery
  import rr_vote_pkg::*;
#(
  parameter int NUM_FU  = DEF_NUM_FU,
  parameter int NUM_OPS = DEF_NUM_OPS,
  parameter int CW_W    = DEF_CW_W,
  parameter int MAX_LAT = DEF_MAX_LAT,
  localparam int OPC_W  = $clog2(NUM_OPS),
  localparam int IDX_W  = $clog2(NUM_FU)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_FU-1:0]               fuValid,
  input  logic [NUM_FU-1:0][OPC_W-1:0]    fuOpc,
  input  logic [NUM_FU-1:0][CW_W-1:0]     fuCtrl,
  input  logic [NUM_FU-1:0][IDX_W-1:0]    fuRef,
  input  logic [NUM_FU-1:0]               errDet,
  input  logic                            voteEq,
  output logic [1:0]                      mode,
  output logic                            stallExec,
  output logic                            stallFetch,
  output logic [NUM_FU-1:0][CW_W-1:0]     ctrlOut,
  output logic [NUM_FU-1:0]               wbEn,
  output logic [NUM_FU-1:0][NUM_OPS-1:0]  faultVec
);

  modeE   modeQ;
  strobeS strobe;
  logic   anyNew;
  logic   pendAny;
  logic   stall;

  rr_mode_ctrl #(
    .MAX_LAT (MAX_LAT)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .anyNew  (anyNew),
    .pendAny (pendAny),
    .modeQ   (modeQ),
    .strobe  (strobe),
    .stall   (stall)
  );

  rr_steer_dp #(
    .NUM_FU  (NUM_FU),
    .NUM_OPS (NUM_OPS),
    .CW_W    (CW_W),
    .OPC_W   (OPC_W),
    .IDX_W   (IDX_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .modeQ    (modeQ),
    .strobe   (strobe),
    .fuValid  (fuValid),
    .fuOpc    (fuOpc),
    .fuCtrl   (fuCtrl),
    .fuRef    (fuRef),
    .errDet   (errDet),
    .voteEq   (voteEq),
    .anyNew   (anyNew),
    .pendAny  (pendAny),
    .ctrlOut  (ctrlOut),
    .wbEn     (wbEn),
    .faultVec (faultVec)
  );

  assign mode       = modeQ;
  assign stallExec  = stall;
  assign stallFetch = stall;

endmodule

// File: tb/test_rr_vote_recovery.sv
`timescale 1ns/1ps
module test_rr_vote_recovery;

  localparam int NF = 4;
  localparam int NO = 4;
  localparam int CW = 12;
  localparam int ML = 2;
  localparam int OW = 2;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [NF-1:0]          fuValid;
  logic [NF-1:0][OW-1:0]  fuOpc;
  logic [NF-1:0][CW-1:0]  fuCtrl;
  logic [NF-1:0][IW-1:0]  fuRef;
  logic [NF-1:0]          errDet;
  logic                   voteEq;
  logic [1:0]             mode;
  logic                   stallExec, stallFetch;
  logic [NF-1:0][CW-1:0]  ctrlOut;
  logic [NF-1:0]          wbEn;
  logic [NF-1:0][NO-1:0]  faultVec;

  rr_vote_recovery #(.NUM_FU(NF), .NUM_OPS(NO), .CW_W(CW), .MAX_LAT(ML)) i_rr_vote_recovery (
    .clk(clk), .rstN(rstN), .fuValid(fuValid), .fuOpc(fuOpc), .fuCtrl(fuCtrl),
    .fuRef(fuRef), .errDet(errDet), .voteEq(voteEq), .mode(mode),
    .stallExec(stallExec), .stallFetch(stallFetch), .ctrlOut(ctrlOut),
    .wbEn(wbEn), .faultVec(faultVec)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [NF-1:0][NO-1:0] mFault;
  logic [NF-1:0]         mPend;
  logic [CW-1:0]         ctxCtrl [NF];
  int                    ctxOpc  [NF];
  int                    ctxRef  [NF];
  int                    mMode, mCnt;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mFault = '0; mPend = '0; mMode = 0; mCnt = 0;
    for (int i = 0; i < NF; i++) begin ctxCtrl[i] = '0; ctxOpc[i] = 0; ctxRef[i] = 0; end
  endtask

  task automatic idleIn();
    fuValid = '0; fuOpc = '0; fuCtrl = '0; fuRef = '0; errDet = '0;
  endtask

  // inputs already driven at the negedge; compare outputs and advance model
  task automatic step();
    logic [NF-1:0][CW-1:0] eCtrl;
    logic [NF-1:0] eWb, newE, freeM;
    string tag;
    int cur, spare, cOpc, cRef;
    bit spOk, fnd;
    #1;
    eCtrl = '0; eWb = '0; newE = '0; tag = "R2";
    cur = 0; spare = 0; spOk = 0; cOpc = 0; cRef = 0;
    if (mMode == 0) begin
      for (int u = 0; u < NF; u++) begin
        newE[u] = fuValid[u] & errDet[u] & ~mFault[u][fuOpc[u]];
        if (errDet[u] && !newE[u]) tag = "R10";
        eCtrl[u] = fuCtrl[u];
        eWb[u] = fuValid[u] & ~newE[u];
      end
      freeM = ~fuValid;
      for (int u = 0; u < NF; u++) begin
        if (fuValid[u] && mFault[u][fuOpc[u]]) begin
          fnd = 0;
          for (int w = 0; w < NF; w++) begin
            if (!fnd && freeM[w] && !mFault[w][fuOpc[u]]) begin
              fnd = 1; freeM[w] = 0; eCtrl[w] = fuCtrl[u]; eWb[w] = 1'b1;
            end
          end
          if (fnd) begin eCtrl[u] = '0; eWb[u] = 1'b0; end
          tag = "R9";
        end
      end
      if ($countones(newE) > 1) tag = "R11";
      else if (newE != 0) tag = "R3";
    end else begin
      for (int i = NF - 1; i >= 0; i--) if (mPend[i]) cur = i;
      cOpc = ctxOpc[cur]; cRef = ctxRef[cur];
      for (int i = NF - 1; i >= 0; i--)
        if (i != cur && i != cRef && !mFault[i][cOpc]) begin spare = i; spOk = 1; end
      tag = "R4";
      if (mMode == 1 && mCnt == 0) begin
        tag = "R5";
        if (spOk) eCtrl[spare] = ctxCtrl[cur];
      end
      if (mMode == 1 && mCnt == ML) begin
        if (spOk && voteEq) begin eWb[spare] = 1'b1; tag = "R6"; end
        else begin eWb[cur] = 1'b1; tag = spOk ? "R7" : "R8"; end
      end
    end
    chk(mode == 2'(mMode), tag, "mode", mode, mMode);
    chk(stallExec == (mMode != 0) && stallFetch == (mMode != 0), tag, "stall",
        {stallExec, stallFetch}, (mMode != 0) ? 3 : 0);
    chk(ctrlOut === eCtrl, tag, "ctrlOut", ctrlOut, eCtrl);
    chk(wbEn === eWb, tag, "wbEn", wbEn, eWb);
    chk(faultVec === mFault, tag, "faultVec", faultVec, mFault);
    // model transition at the coming edge
    if (mMode == 0) begin
      if (newE != 0) begin
        mPend = newE;
        for (int u = 0; u < NF; u++) if (newE[u]) begin
          ctxCtrl[u] = fuCtrl[u]; ctxOpc[u] = fuOpc[u]; ctxRef[u] = fuRef[u];
        end
        mMode = 1; mCnt = 0;
      end
    end else if (mMode == 1) begin
      if (mCnt == ML) begin
        if (spOk && voteEq) mFault[cur][cOpc] = 1'b1;
        else if (spOk) mFault[cRef][cOpc] = 1'b1;
        mPend[cur] = 1'b0;
        mMode = 2; mCnt = 0;
      end else mCnt++;
    end else begin
      if (mCnt == ML - 1) begin
        mMode = (mPend != 0) ? 1 : 0; mCnt = 0;
      end else mCnt++;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; idleIn(); voteEq = 1'b0; modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(mode == 2'd0, "R1", "mode in reset", mode, 0);
    chk(!stallExec && !stallFetch, "R1", "stall in reset", {stallExec, stallFetch}, 0);
    chk(faultVec == '0, "R1", "faultVec in reset", faultVec, 0);
    rstN = 1'b1;
  endtask

  task automatic randIn(input int errPct);
    for (int u = 0; u < NF; u++) begin
      fuValid[u] = ($urandom % 10) < 6;
      fuOpc[u]   = OW'($urandom % NO);
      fuCtrl[u]  = CW'($urandom);
      fuRef[u]   = IW'((u + 1 + ($urandom % (NF - 1))) % NF);
      errDet[u]  = ($urandom % 100) < errPct;
    end
    voteEq = 1'($urandom % 2);
  endtask

  // one new fault on unit u, then the full stall window
  task automatic fault1(input int u, input int r, input int opc, input bit eq);
    int n;
    @(negedge clk);
    idleIn();
    fuValid[u] = 1'b1; fuOpc[u] = OW'(opc); fuCtrl[u] = CW'(12'h5A0 + u);
    fuRef[u] = IW'(r); errDet[u] = 1'b1; voteEq = eq;
    step();
    n = 0;
    for (int k = 0; k < 2 * ML + 2; k++) begin
      @(negedge clk); idleIn(); step();
      if (stallExec) n++;
    end
    chk(n == 2 * ML + 1, "R4", "stall cycles per fault", n, 2 * ML + 1);
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idleIn(); voteEq = 1'b0; modelReset();
    doReset();

    // R2: plain pass-through under random occupancy
    for (int k = 0; k < 20; k++) begin @(negedge clk); randIn(0); step(); end

    // R6: replay agrees with reference -> unit 1 operator 1 broken
    fault1(1, 2, 1, 1'b1);
    chk(faultVec[1][1] == 1'b1, "R6", "flagged unit marked", faultVec[1][1], 1);

    // R9: unit 1 operator 1 moved to idle unit 0 in the same cycle
    @(negedge clk); idleIn();
    fuValid[1] = 1'b1; fuOpc[1] = 2'd1; fuCtrl[1] = 12'h3C3;
    step();
    chk(ctrlOut[0] == 12'h3C3 && wbEn == 4'b0001, "R9", "redirect target",
        {ctrlOut[0], wbEn}, {12'h3C3, 4'b0001});

    // R10: report on a known-broken slot is ignored
    @(negedge clk); idleIn();
    fuValid[1] = 1'b1; fuOpc[1] = 2'd1; errDet[1] = 1'b1; fuCtrl[1] = 12'h111;
    step();
    @(negedge clk); idleIn(); step();
    chk(mode == 2'd0, "R10", "mode after ignored report", mode, 0);

    // R7: replay disagrees -> reference unit 0 operator 3 broken
    fault1(2, 0, 3, 1'b0);
    chk(faultVec[0][3] == 1'b1, "R7", "reference unit marked", faultVec[0][3], 1);

    // R11: two reports in one cycle, voted lowest first, back to back
    @(negedge clk); idleIn();
    fuValid = 4'b1100; fuOpc[2] = 2'd2; fuOpc[3] = 2'd2;
    fuCtrl[2] = 12'h222; fuCtrl[3] = 12'h333; fuRef[2] = 2'd0; fuRef[3] = 2'd1;
    errDet = 4'b1100; voteEq = 1'b1;
    step();
    for (int k = 0; k < 4 * ML + 4; k++) begin @(negedge clk); idleIn(); step(); end
    chk(faultVec[2][2] && faultVec[3][2], "R11", "both pending voted",
        {faultVec[2][2], faultVec[3][2]}, 2'b11);

    // R8: no spare left for operator 0
    doReset();
    fault1(2, 0, 0, 1'b1);
    fault1(3, 0, 0, 1'b1);
    fault1(0, 1, 0, 1'b1);
    chk(faultVec[0][0] == 1'b0 && faultVec[1][0] == 1'b0, "R8", "no mark without spare",
        {faultVec[0][0], faultVec[1][0]}, 0);

    // random mix of redirection and new reports
    doReset();
    for (int k = 0; k < 1500; k++) begin @(negedge clk); randIn(8); step(); end
    doReset();
    for (int k = 0; k < 1500; k++) begin @(negedge clk); randIn(4); step(); end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule